// File: doc/BRIEF.md
# Selectable-Rate Periodic Interrupt Generator

This block turns a 256 Hz timebase enable from a real-time-clock prescaler into periodic interrupt events at one of six rates. Software picks the rate through a 3-bit select field in an 8-bit control register. On every completed period the block sets a sticky flag in the same register and raises an interrupt request. Software acknowledges by writing the flag bit as 0.

The low four bits of the register hold the clock's enable, adjust, reset and start controls. Software updates the register by read-modify-write, so the block stores those bits exactly as written and never alters them itself. When the select field changes, the internal divider restarts from zero, so the first event after a rate change always comes a full period later. The block has no data stream: the timebase enable, the register write strobe and the interrupt request are plain control pins.

Top module: `prdgen_top`

## Requirements
- R1: After reset the control register reads 0x00 and `irq` is 0.
- R2: Register layout: bit 7 is the periodic flag, bits 6:4 are the select code, bits 3:0 are control bits. A write stores bits 6:0 as given. Without a write, bits 6:0 keep their values.
- R3: The select code sets the period, counted in `tick_256` pulses: code 1 gives 1 (256 Hz), code 2 gives 4 (64 Hz), code 3 gives 16 (16 Hz), code 4 gives 64 (4 Hz), code 5 gives 128 (2 Hz) and code 6 gives 256 (1 Hz).
- R4: Code 0 and the reserved code 7 produce no events, however many ticks arrive.
- R5: The tick that completes a period sets the flag. The flag reads 1 in the cycle after that tick.
- R6: A write with bit 7 = 0 clears the flag. A write with bit 7 = 1 leaves the flag as it was.
- R7: When a period completes in the same cycle as a clearing write, the flag stays 1.
- R8: A write that changes the select code restarts the divider: the first event comes on the full-period tick counted from the first tick after that write. A write that keeps the same code does not restart the divider.
- R9: `irq` is 1 exactly while the flag is 1 and the select code is nonzero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_256 | input | 1 | One-cycle enable pulse at 256 Hz from the prescaler |
| ctl_wr | input | 1 | Write strobe for the control register |
| ctl_wdata | input | 8 | Write data for the control register |
| ctl_rdata | output | 8 | Current control register value: flag, select code, control bits |
| irq | output | 1 | Periodic interrupt request |

## Verification
The bench counts ticks from each rate write until the flag rises, for every code. A divider with a wrong terminal count or an off-by-one would set the flag one tick early or late. It also drives a clearing write in the same cycle as a completing tick: a design that gave priority to the clear would drop that event. Rewriting the same code partway through a period, and changing the code partway through a period, expose a divider that restarts when it should not, or keeps a stale count when it should restart. Random rounds write codes 0 and 7 with long tick bursts, which would catch a design that lets the reserved code count, and they check that the control bits read back unchanged.

// File: rtl/prdgen_pkg.sv
package prdgen_pkg;
  localparam int REG_W    = 8;
  localparam int FLAG_BIT = 7;
  localparam int SEL_LSB  = 4;
  localparam int SEL_W    = 3;
  localparam int CTL_W    = SEL_LSB;
  localparam int CNT_W    = 8;

  // terminal count (period minus one) in base ticks for each select code
  function automatic logic [CNT_W-1:0] term_count(input logic [SEL_W-1:0] code);
    case (code)
      3'd1:    term_count = CNT_W'(0);
      3'd2:    term_count = CNT_W'(3);
      3'd3:    term_count = CNT_W'(15);
      3'd4:    term_count = CNT_W'(63);
      3'd5:    term_count = CNT_W'(127);
      3'd6:    term_count = CNT_W'(255);
      default: term_count = '0;
    endcase
  endfunction

  function automatic logic code_active(input logic [SEL_W-1:0] code);
    code_active = (code != '0) && (code != '1);
  endfunction
endpackage

// File: rtl/prdgen_decode.sv
module prdgen_decode
  import prdgen_pkg::*;
(
  input  logic [SEL_W-1:0] sel,
  output logic             active,
  output logic [CNT_W-1:0] tc
);
  always_comb begin
    active = code_active(sel);
    tc     = term_count(sel);
  end
endmodule

// File: rtl/prdgen_divider.sv
module prdgen_divider
  import prdgen_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             active,
  input  logic [CNT_W-1:0] tc,
  input  logic             restart,
  output logic             evt
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                 cnt <= '0;
    else if (restart || !active) cnt <= '0;
    else if (tick)              cnt <= (cnt == tc) ? '0 : cnt + 1'b1;
  end

  always_comb evt = tick && active && !restart && (cnt == tc);

  // R8
  restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt == '0));
  // R3
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && active && !restart && (cnt != tc)) |=> (cnt == CNT_W'($past(cnt) + 1'b1)));
  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (cnt == '0));
endmodule

// File: rtl/prdgen_ctl.sv
module prdgen_ctl
  import prdgen_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [REG_W-1:0] wdata,
  input  logic             evt,
  output logic             flag,
  output logic [SEL_W-1:0] sel,
  output logic [CTL_W-1:0] ctl_bits,
  output logic             sel_chg
);
  logic [SEL_W-1:0] new_sel;

  always_comb begin
    new_sel = wdata[SEL_LSB +: SEL_W];
    sel_chg = wr && (new_sel != sel);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel      <= '0;
      ctl_bits <= '0;
    end else if (wr) begin
      sel      <= new_sel;
      ctl_bits <= wdata[CTL_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                         flag <= 1'b0;
    else if (evt)                       flag <= 1'b1;
    else if (wr && !wdata[FLAG_BIT])    flag <= 1'b0;
  end

  // R5
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> flag);
  // R6
  flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !wdata[FLAG_BIT] && !evt) |=> !flag);
  // R2
  ctl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> ($stable(sel) && $stable(ctl_bits)));
endmodule

// File: rtl/prdgen_top.sv
module prdgen_top
  import prdgen_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_256,
  input  logic             ctl_wr,
  input  logic [REG_W-1:0] ctl_wdata,
  output logic [REG_W-1:0] ctl_rdata,
  output logic             irq
);
  logic             flag, sel_chg, active, evt;
  logic [SEL_W-1:0] sel;
  logic [CTL_W-1:0] ctl_bits;
  logic [CNT_W-1:0] tc;

  prdgen_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .wr(ctl_wr), .wdata(ctl_wdata), .evt(evt),
    .flag(flag), .sel(sel), .ctl_bits(ctl_bits), .sel_chg(sel_chg)
  );

  prdgen_decode u_dec (.sel(sel), .active(active), .tc(tc));

  prdgen_divider u_div (
    .clk(clk), .rst_n(rst_n), .tick(tick_256), .active(active), .tc(tc),
    .restart(sel_chg), .evt(evt)
  );

  always_comb begin
    ctl_rdata = {flag, sel, ctl_bits};
    irq       = flag && (sel != '0);
  end

  // R9
  irq_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && !ctl_wdata[FLAG_BIT] && !evt) |=> !irq);
endmodule

// File: tb/prdgen_top_tb.sv
`timescale 1ns/1ps
module prdgen_top_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_256 = 1'b0;
  logic       ctl_wr = 1'b0;
  logic [7:0] ctl_wdata = 8'h00;
  logic [7:0] ctl_rdata;
  logic       irq;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  prdgen_top u_dut (.clk(clk), .rst_n(rst_n), .tick_256(tick_256), .ctl_wr(ctl_wr),
                    .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata), .irq(irq));

  always #4 clk = ~clk;

  function automatic int period_of(input int code);
    case (code)
      1: return 1;
      2: return 4;
      3: return 16;
      4: return 64;
      5: return 128;
      6: return 256;
      default: return 0;
    endcase
  endfunction

  function automatic bit flag_expect(input int code, input int ticks);
    return (period_of(code) != 0) && (ticks >= period_of(code));
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cycle(input bit t, input bit w, input logic [7:0] d);
    @(negedge clk);
    tick_256 = t; ctl_wr = w; ctl_wdata = d;
    @(negedge clk);
    tick_256 = 1'b0; ctl_wr = 1'b0;
  endtask

  task automatic wr(input logic [7:0] d); cycle(1'b0, 1'b1, d); endtask
  task automatic tk(input int n);
    for (int i = 0; i < n; i++) cycle(1'b1, 1'b0, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 rdata", ctl_rdata, 8'h00);
    chk("R1 irq", irq, 0);

    // R4 code 0 after reset: no events
    tk(300);
    chk("R4 code0 flag", ctl_rdata[7], 0);

    // R3 R5 every code: flag low one tick short, high on the period tick
    for (int c = 1; c <= 6; c++) begin
      wr({1'b0, 3'(c), 4'h5});
      tk(period_of(c) - 1);
      chk($sformatf("R3 code%0d early", c), ctl_rdata[7], 0);
      tk(1);
      chk($sformatf("R5 code%0d set", c), ctl_rdata[7], 1);
      chk("R9 irq on", irq, 1);
      chk("R2 readback", ctl_rdata[6:0], {3'(c), 4'h5});
    end

    // R6 write with bit7=1 keeps flag, bit7=0 clears it
    wr(8'hEA);
    chk("R6 keep", ctl_rdata, 8'hEA);
    wr(8'h6A);
    chk("R6 clear", ctl_rdata[7], 0);
    chk("R9 irq off", irq, 0);

    // R7 event and clearing write in the same cycle
    wr(8'h10);
    cycle(1'b1, 1'b1, 8'h13);
    chk("R7 set wins", ctl_rdata, 8'h93);

    // R9 flag held under code 7 and code 0
    wr(8'hF3);
    chk("R9 code7 irq", irq, 1);
    wr(8'h83);
    chk("R9 code0 irq", irq, 0);
    chk("R9 code0 flag", ctl_rdata[7], 1);

    // R4 reserved code 7 never counts
    wr(8'h70);
    tk(300);
    chk("R4 code7 flag", ctl_rdata[7], 0);

    // R8 same code rewrite does not restart
    wr(8'h20);
    tk(2);
    wr(8'h29);
    tk(1);
    chk("R8 no restart early", ctl_rdata[7], 0);
    tk(1);
    chk("R8 no restart set", ctl_rdata[7], 1);

    // R8 changing code restarts divider
    wr(8'h30);
    tk(10);
    wr(8'h20);
    tk(3);
    chk("R8 restart early", ctl_rdata[7], 0);
    tk(1);
    chk("R8 restart set", ctl_rdata[7], 1);

    // random rounds
    void'($urandom(32'd1234));
    for (int r = 0; r < 30; r++) begin
      int code, n;
      logic [3:0] lo;
      code = $urandom_range(0, 7);
      lo = 4'($urandom_range(0, 15));
      n = $urandom_range(0, 300);
      if (code == (ctl_rdata[6:4] == 3'(code) ? code : -1)) wr(8'h00);
      wr({1'b0, 3'(code), lo});
      tk(n);
      chk("R3 R4 random flag", ctl_rdata[7], flag_expect(code, n));
      chk("R9 random irq", irq, flag_expect(code, n) && code != 0);
      chk("R2 random low", ctl_rdata[6:0], {3'(code), lo});
    end

    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule